// File: doc/BRIEF.md
# GPIO Direction, Data and Bias Register Bank

This block holds the per-pin configuration of a group of general-purpose pads: whether each pad drives or listens, the level it drives, and whether a weak bias resistor is on and which way it pulls. Software reaches it through a plain word-wide register port. Pins are grouped in banks. Each bank owns an unbroken run of bits inside shared 32-bit registers. The run for bank k starts at a bit offset set by a parameter, so two or more banks can sit side by side in one word.

The pad levels are brought into the clock domain by a two-stage synchroniser before they can be read back. A parameter chooses between two layouts for the bias controls. In one, the bias enable bits and the up/down bits have separate registers. In the other, both kinds of bit share the enable register at different offsets.

Register words, each 32 bits:

| Address | Contents |
|---|---|
| 0 | direction, 1 = input |
| 1 | output value |
| 2 | synchronised input level |
| 3 | bias enable |
| 4 | bias up/down, only when the bias fields are not shared |

Top module: `gpio_cfg_bank`

## Requirements
- R1: In the direction, output and input words, pin p of bank k sits at bit `GPIO_BIT[k] + p - BANK_FIRST[k]`. In the bias-enable word it sits at bit `PEN_BIT[k] + p - BANK_FIRST[k]`, and in the up/down field at bit `PUP_BIT[k] + p - BANK_FIRST[k]`. Bits not mapped to a pin read 0, and writes to them change nothing.
- R2: Address 0 holds the direction bits. A bit of 1 makes the pin an input, with its `pad_oe` low. A bit of 0 makes it an output, with `pad_oe` high in the cycle after the write.
- R3: Address 1 holds the output bits. Each bit appears on the pin's `pad_out` in the cycle after the write, and the word reads back as written, limited to the mapped bits.
- R4: Address 2 reads the pad levels through two flops. A change on `pad_in` is not yet visible after one rising edge, and it is visible after the second.
- R5: Writes to address 2 leave every stored bit and every pad output unchanged.
- R6: Address 3 holds the bias enables. An enable of 0 means no bias (`pad_pull_en` low). An enable of 1 turns the bias on, and the pin's up/down bit then chooses pull-up (1) or pull-down (0) on `pad_pull_up`.
- R7: With `PULL_SHARED`=0 the up/down bits are at address 4. With `PULL_SHARED`=1 they are in the address-3 word at the `PUP_BIT` offsets. In that case address 4 reads 0 and writes to it are ignored.
- R8: Several banks share one word. In the default layout, pins 0–5 use bits 0–5 and pins 6–11 use bits 16–21 of the direction, output and input words. In the enable word those pins use bits 0–5 and 8–13, and in the up/down field bits 16–21 and 24–29.
- R9: After reset every direction bit is 1, and every output, enable and up/down bit is 0.
- R10: Addresses 5 to 7 read 0, and writes to them have no effect.
- R11: `bus_rdata` is combinational and reflects `bus_addr` in the same cycle. A write takes effect at the rising edge where `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| bus_wr | input | 1 | write strobe for the word at `bus_addr` |
| bus_addr | input | 3 | register word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| pad_in | input | NUM_PINS | pad levels, asynchronous |
| pad_out | output | NUM_PINS | level each pin drives |
| pad_oe | output | NUM_PINS | drive enable, high when the pin is an output |
| pad_pull_en | output | NUM_PINS | bias resistor on |
| pad_pull_up | output | NUM_PINS | bias direction, 1 up, 0 down |

## Verification
Two functions can meet in a single cycle: input sampling and a register write aimed at the input word. The bench provokes this by changing `pad_in` in the same cycle that it writes all ones to address 2. It then judges the result two ways. The input word must show the new pad level only after the second edge. The direction and output words and the pad controls must be left unchanged. A second collision arises in the shared-bias layout, where one write to address 3 updates a pin's enable and another pin's up/down bit together. A second instance with that layout checks that both effects land and that address 4 stays dead.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [2:0] ADR_DIR = 3'd0;
  localparam logic [2:0] ADR_OUT = 3'd1;
  localparam logic [2:0] ADR_IN  = 3'd2;
  localparam logic [2:0] ADR_PEN = 3'd3;
  localparam logic [2:0] ADR_PUP = 3'd4;

  typedef struct packed {
    logic dir;   // 1 = input
    logic out;
    logic pen;
    logic pup;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{dir: 1'b1, out: 1'b0, pen: 1'b0, pup: 1'b0};
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // checker-side age counter: two edges seen since reset released
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)               warm <= 2'd0;
    else if (warm != 2'd2)    warm <= warm + 2'd1;
  end

  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpb_pin_cell.sv
module gpb_pin_cell
  import gpb_pkg::*;
#(
  parameter bit SHARED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] waddr,
  input  logic       w_g,   // bit from the GPIO-word position
  input  logic       w_p,   // bit from the enable position
  input  logic       w_u,   // bit from the up/down position
  output pin_cfg_t   cfg
);
  localparam logic [2:0] PUP_ADR = SHARED ? ADR_PEN : ADR_PUP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (wr) begin
      if (waddr == ADR_DIR) cfg.dir <= w_g;
      if (waddr == ADR_OUT) cfg.out <= w_g;
      if (waddr == ADR_PEN) cfg.pen <= w_p;
      if (waddr == PUP_ADR) cfg.pup <= w_u;
    end
  end

  // R5: a write to the input word touches no stored bit
  a_r5_in_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && waddr == ADR_IN) |=> ($stable(cfg.dir) && $stable(cfg.out) &&
                                 $stable(cfg.pen) && $stable(cfg.pup)));

  // R7: up/down bit is loaded from whichever word the layout picks
  a_r7_pup_source: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && waddr == PUP_ADR) |=> (cfg.pup == $past(w_u)));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpb_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned NUM_BANKS   = 2,
  parameter bit          PULL_SHARED = 1'b0,
  parameter logic [8*NUM_BANKS-1:0] BANK_FIRST = {8'd6,  8'd0},
  parameter logic [8*NUM_BANKS-1:0] BANK_LAST  = {8'd11, 8'd5},
  parameter logic [8*NUM_BANKS-1:0] GPIO_BIT   = {8'd16, 8'd0},
  parameter logic [8*NUM_BANKS-1:0] PEN_BIT    = {8'd8,  8'd0},
  parameter logic [8*NUM_BANKS-1:0] PUP_BIT    = {8'd24, 8'd16}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pull_en,
  output logic [NUM_PINS-1:0] pad_pull_up
);
  function automatic int bank_of(int p);
    int k_hit = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (p >= int'(BANK_FIRST[8*k +: 8]) && p <= int'(BANK_LAST[8*k +: 8]))
        k_hit = k;
    return k_hit;
  endfunction

  function automatic int bit_at(logic [8*NUM_BANKS-1:0] base, int p);
    int k = bank_of(p);
    return int'(base[8*k +: 8]) + p - int'(BANK_FIRST[8*k +: 8]);
  endfunction

  logic [NUM_PINS-1:0] in_sync;
  logic [WORD_W-1:0]   contrib [NUM_PINS];

  gpb_sync #(.W(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (in_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int GB = bit_at(GPIO_BIT, p);
    localparam int PB = bit_at(PEN_BIT, p);
    localparam int UB = bit_at(PUP_BIT, p);
    pin_cfg_t cfg;

    gpb_pin_cell #(.SHARED(PULL_SHARED)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (bus_wr),
      .waddr(bus_addr),
      .w_g  (bus_wdata[GB]),
      .w_p  (bus_wdata[PB]),
      .w_u  (bus_wdata[UB]),
      .cfg  (cfg)
    );

    assign pad_out[p]     = cfg.out;
    assign pad_oe[p]      = ~cfg.dir;
    assign pad_pull_en[p] = cfg.pen;
    assign pad_pull_up[p] = cfg.pup;

    always_comb begin
      contrib[p] = '0;
      case (bus_addr)
        ADR_DIR: contrib[p][GB] = cfg.dir;
        ADR_OUT: contrib[p][GB] = cfg.out;
        ADR_IN:  contrib[p][GB] = in_sync[p];
        ADR_PEN: begin
          contrib[p][PB] = cfg.pen;
          if (PULL_SHARED) contrib[p][UB] = cfg.pup;
        end
        ADR_PUP: if (!PULL_SHARED) contrib[p][UB] = cfg.pup;
        default: ;
      endcase
    end

    // R2: pad drive follows the direction bit written one cycle earlier
    a_r2_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_DIR) |=> (pad_oe[p] == !$past(bus_wdata[GB])));

    // R3: driven level follows the output bit written one cycle earlier
    a_r3_out_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_OUT) |=> (pad_out[p] == $past(bus_wdata[GB])));
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) bus_rdata = bus_rdata | contrib[p];
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R10: addresses above the map read as zero
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADR_PUP) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_cfg_bank.sv
`timescale 1ns/1ps
module sim_gpio_cfg_bank;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = 3'd0;
  logic [31:0]   bus_wdata = '0;
  logic [N-1:0]  pad_in = '0;
  logic [31:0]   rd0, rd1;
  logic [N-1:0]  out0, oe0, pen0, pup0;
  logic [N-1:0]  out1, oe1, pen1, pup1;

  int nvec = 0;
  int nmis = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_cfg_bank #(.PULL_SHARED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .pad_in(pad_in),
    .pad_out(out0), .pad_oe(oe0), .pad_pull_en(pen0), .pad_pull_up(pup0));

  gpio_cfg_bank #(.PULL_SHARED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .pad_in(pad_in),
    .pad_out(out1), .pad_oe(oe1), .pad_pull_en(pen1), .pad_pull_up(pup1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nmis++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_word(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_both(input logic [2:0] a, output logic [31:0] v0, output logic [31:0] v1);
    bus_addr = a;
    #2;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic t_reset;  // R9
    logic [31:0] a, b;
    rd_both(3'd0, a, b); check("R9 dir word", a, 32'h003F003F);
    rd_both(3'd1, a, b); check("R9 out word", a, 32'h0);
    rd_both(3'd3, a, b); check("R9 pen word", a, 32'h0);
    check("R9 oe", 32'(oe0), 32'h0);
    check("R9 pull_en", 32'(pen0), 32'h0);
    check("R9 pull_up", 32'(pup0), 32'h0);
  endtask

  task automatic t_dir_out;  // R2 R3 R8
    logic [31:0] a, b;
    wr_word(3'd0, 32'h0);
    check("R2 all outputs", 32'(oe0), 32'hFFF);
    wr_word(3'd1, 32'h002A0015);
    check("R8 two banks in one word", 32'(out0), 32'hA95);
    rd_both(3'd1, a, b); check("R3 out readback", a, 32'h002A0015);
    wr_word(3'd0, 32'h00010002);
    check("R2 pins 1 and 6 inputs", 32'(oe0), 32'hFBD);
  endtask

  task automatic t_unmapped;  // R1 R10
    logic [31:0] a, b;
    wr_word(3'd1, 32'hFFFFFFFF);
    rd_both(3'd1, a, b); check("R1 unmapped bits read 0", a, 32'h003F003F);
    check("R1 all outputs high", 32'(out0), 32'hFFF);
    wr_word(3'd5, 32'hFFFFFFFF);
    wr_word(3'd7, 32'hFFFFFFFF);
    for (int k = 5; k < 8; k++) begin
      rd_both(3'(k), a, b); check("R10 hole reads 0", a, 32'h0);
    end
    rd_both(3'd0, a, b); check("R10 hole write inert", a, 32'h00010002);
  endtask

  task automatic t_input;  // R4 R5 R11
    logic [31:0] a, b;
    @(negedge clk); pad_in = 12'hABC;
    @(negedge clk);
    rd_both(3'd2, a, b); check("R4 not visible after one edge", a, 32'h0);
    @(negedge clk);
    rd_both(3'd2, a, b); check("R4 visible after two edges", a, 32'h002A003C);
    check("R11 both instances agree", b, 32'h002A003C);
    // collision: pad changes in the cycle of a write to the input word
    @(negedge clk);
    pad_in = 12'h543; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_both(3'd2, a, b); check("R5 write ignored, old level", a, 32'h002A003C);
    @(negedge clk);
    rd_both(3'd2, a, b); check("R4 new level after collision", a, 32'h00150003);
    rd_both(3'd0, a, b); check("R5 dir unchanged", a, 32'h00010002);
    rd_both(3'd1, a, b); check("R5 out unchanged", a, 32'h003F003F);
    check("R5 oe unchanged", 32'(oe0), 32'hFBD);
    check("R5 pull_en unchanged", 32'(pen0), 32'h0);
  endtask

  task automatic t_pull;  // R6 R7
    logic [31:0] a, b;
    wr_word(3'd3, 32'h00003F00);
    check("R6 bank1 bias on", 32'(pen0), 32'hFC0);
    check("R6 default pull-down", 32'(pup0), 32'h0);
    wr_word(3'd4, 32'h03000000);
    check("R6 pins 6,7 pull-up", 32'(pup0), 32'h0C0);
    rd_both(3'd3, a, b); check("R6 pen readback", a, 32'h00003F00);
    rd_both(3'd4, a, b); check("R7 separate pup word", a, 32'h03000000);
  endtask

  task automatic t_shared;  // R7
    logic [31:0] a, b;
    wr_word(3'd3, 32'h01000001);
    check("R7 shared enable pin 0", 32'(pen1), 32'h001);
    check("R7 shared up pin 6", 32'(pup1), 32'h040);
    wr_word(3'd4, 32'hFFFFFFFF);
    check("R7 shared ignores addr 4", 32'(pup1), 32'h040);
    rd_both(3'd4, a, b);
    check("R7 shared addr 4 reads 0", b, 32'h0);
    check("R7 separate pup all set", a, 32'h3F3F0000);
    rd_both(3'd3, a, b);
    check("R7 shared word readback", b, 32'h01000001);
    check("R6 separate pen word", a, 32'h00000001);
    check("R6 separate layout all up", 32'(pup0), 32'hFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_unmapped();
    t_input();
    t_pull();
    t_shared();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nvec++; nmis++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end
endmodule